// File: doc/BRIEF.md
# Three-Wire Serial Word Memory, Read Path

This block is the slave end of a three-wire serial memory link. It holds a small array of 16-bit words and answers read commands from a master. The master drives a select line, a serial clock and a serial data line. The block returns words on a data-out line, with an enable that stands for the high-impedance state. All three link inputs are oversampled by a fast core clock and passed through a short synchronizer. Rising edges of the serial clock are found inside the core clock domain.

A command starts when the master raises select. Serial-clock rises that sample the data line low are discarded until the first one that samples it high, which acts as the start bit. Next come a two-bit opcode and an address, both most significant bit first. For a read, the block drives a single 0 and then the addressed word. While the serial clock keeps running it streams the following words, and after the top address it continues from address zero. A parallel preload port fills the word array before any serial traffic.

Top module: `tw_serial_mem`

## Requirements
- R1: While select is low, data-out is not enabled (high impedance), and serial-clock and data-in activity is ignored. In particular, such activity cannot start a command.
- R2: After select rises, every serial-clock rise that samples data-in at 0 before the start bit is discarded. Any number of these dummy clocks may precede a command.
- R3: A command is the start bit (data-in 1), then a two-bit opcode, then an ADDR_W-bit address (6 by default), each field most significant bit first. Data-out stays disabled while the command is shifted in.
- R4: The read opcode is the bit pair 1 then 0. Any other opcode makes the block disregard all further input, with data-out disabled, until select goes low.
- R5: On the serial-clock rise that shifts in the last address bit of a read, data-out becomes enabled and drives 0. It holds that 0 until the next serial-clock rise.
- R6: Each later serial-clock rise launches one bit of the addressed 16-bit word, most significant bit first. Data-out changes only after a serial-clock rise, so the master samples it on the following rise.
- R7: After the 16th bit of a word, further rises stream the word at the next address immediately, with no extra 0 between words.
- R8: During a streamed read, the address after the all-ones address is zero.
- R9: Lowering select ends the current command at once, including a read in mid-word. The next select period needs a new start bit, and dummy clocks may come before it.
- R10: When the preload enable is high on a core clock edge, the preload data is written into the word at the preload address. A later read returns it.
- R11: While reset is asserted, data-out is disabled and the command decoder waits for a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select from the master, active high |
| sk | input | 1 | Serial clock from the master |
| di | input | 1 | Serial data from the master |
| do_data | output | 1 | Serial data to the master |
| do_oe | output | 1 | Data-out enable; low means high impedance |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | ADDR_W | Preload word address |
| pre_data | input | WORD_W | Preload word value |

## Verification
The checker watches every core cycle for four things. Data-out is disabled one cycle after select is seen low. The decoder state and data-out move only on a detected serial-clock rise. The enable only ever rises out of the address phase, and it carries a 0 when it does. A rejected opcode stays rejected while select holds. The serial values themselves can only be shown by the bench's scenarios: the word order, bit order and contents, the step from one word to the next, the wrap from the top address to zero, the skipped dummy clocks, and recovery after an aborted read. For these, a scoreboard holds each expected data-out value and compares it against the line at every serial-clock rise.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_OPC,
    ST_ADDR,
    ST_DRIVE,
    ST_IGNORE
  } tw_state_e;

  localparam int          OPC_BITS = 2;
  localparam logic [1:0]  OP_READ  = 2'b10;

endpackage

// File: rtl/tw_in_sync.sv
module tw_in_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        pipe[i] <= pipe[i-1];
      end
      pipe[0] <= din;
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/tw_word_array.sv
module tw_word_array #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tw_read_ctrl.sv
module tw_read_ctrl
  import tw_mem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_s,
  input  logic              di_s,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sk_rise,
  output tw_state_e         state,
  output logic              do_data,
  output logic              do_oe
);

  localparam int MAXF = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
  localparam int CW   = $clog2(MAXF) + 1;

  tw_state_e         state_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [1:0]        opc, opc_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              do_q, do_n;
  logic              sk_q;
  logic              step_en;
  logic [WORD_W-1:0] shifted;

  assign sk_rise = sk_s & ~sk_q;
  assign step_en = sk_rise | ~cs_s;
  assign shifted = rd_word << cnt;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    opc_n   = opc;
    addr_n  = addr;
    do_n    = do_q;
    if (!cs_s) begin
      state_n = ST_HUNT;
      cnt_n   = '0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (di_s) begin
            state_n = ST_OPC;
            cnt_n   = '0;
          end
        end
        ST_OPC: begin
          opc_n = {opc[0], di_s};
          if (cnt == CW'(OPC_BITS - 1)) begin
            cnt_n   = '0;
            state_n = ({opc[0], di_s} == OP_READ) ? ST_ADDR : ST_IGNORE;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        ST_ADDR: begin
          addr_n = {addr[ADDR_W-2:0], di_s};
          if (cnt == CW'(ADDR_W - 1)) begin
            cnt_n   = '0;
            state_n = ST_DRIVE;
            do_n    = 1'b0;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        ST_DRIVE: begin
          do_n = shifted[WORD_W-1];
          if (cnt == CW'(WORD_W - 1)) begin
            cnt_n  = '0;
            addr_n = addr + ADDR_W'(1);
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        default: begin
          state_n = ST_IGNORE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
    end else begin
      sk_q <= sk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      cnt   <= '0;
      opc   <= '0;
      addr  <= '0;
      do_q  <= 1'b0;
    end else if (step_en) begin
      state <= state_n;
      cnt   <= cnt_n;
      opc   <= opc_n;
      addr  <= addr_n;
      do_q  <= do_n;
    end
  end

  assign rd_addr = addr;
  assign do_data = do_q;
  assign do_oe   = (state == ST_DRIVE);

endmodule

// File: rtl/tw_serial_mem.sv
module tw_serial_mem
  import tw_mem_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  output logic              do_data,
  output logic              do_oe,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data
);

  logic              cs_s, sk_s, di_s;
  logic              sk_rise;
  tw_state_e         state;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;

  tw_in_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({cs, sk, di}),
    .dout  ({cs_s, sk_s, di_s})
  );

  tw_word_array #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_array (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  tw_read_ctrl #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .sk_s    (sk_s),
    .di_s    (di_s),
    .rd_word (rd_word),
    .rd_addr (rd_addr),
    .sk_rise (sk_rise),
    .state   (state),
    .do_data (do_data),
    .do_oe   (do_oe)
  );

endmodule

// File: rtl/tw_serial_mem_chk.sv
module tw_serial_mem_chk
  import tw_mem_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_s,
  input logic      sk_rise,
  input tw_state_e state,
  input logic      do_data,
  input logic      do_oe
);

  assert_standby_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !do_oe);

  assert_abort_to_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (state == ST_HUNT));

  assert_step_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !sk_rise) |=> $stable(state));

  assert_ignore_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && state == ST_IGNORE) |=> (state == ST_IGNORE));

  assert_lead_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> (!do_data && $past(state) == ST_ADDR));

  assert_hold_between_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !sk_rise) |=> $stable(do_data));

endmodule

bind tw_serial_mem tw_serial_mem_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_s    (cs_s),
  .sk_rise (sk_rise),
  .state   (state),
  .do_data (do_data),
  .do_oe   (do_oe)
);

// File: tb/tw_serial_mem_test.sv
`timescale 1ns/1ps
module tw_serial_mem_test;

  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs, sk, di;
  logic          pre_we;
  logic [AW-1:0] pre_addr;
  logic [DW-1:0] pre_data;
  logic          do_data, do_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DW-1:0] model [DEPTH];

  typedef struct {
    logic  oe;
    logic  val;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  tw_serial_mem #(.ADDR_W(AW), .WORD_W(DW)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .sk       (sk),
    .di       (di),
    .do_data  (do_data),
    .do_oe    (do_oe),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data)
  );

  function automatic logic [DW-1:0] pat(int a);
    return {8'(a) ^ 8'h96, 8'(a * 37 + 11)};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares data-out against the scoreboard at every serial-clock rise.
  always @(posedge sk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (e.oe) begin
        if (do_oe !== 1'b1 || do_data !== e.val) begin
          errors++;
          $display("FAIL %s: oe/data actual %b/%b expected 1/%b", e.tag, do_oe, do_data, e.val);
        end
      end else if (do_oe !== 1'b0) begin
        errors++;
        $display("FAIL %s: oe actual %b expected 0", e.tag, do_oe);
      end
    end
  end

  task automatic pulse(logic d, logic eoe, logic ev, string tag);
    exp_t e;
    e.oe = eoe; e.val = ev; e.tag = tag;
    di = d;
    exp_q.push_back(e);
    sk = 1'b1;
    tick(HALF);
    sk = 1'b0;
    tick(HALF);
  endtask

  task automatic direct_check(logic cond, string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send_cmd(logic [1:0] op, logic [AW-1:0] a, int dummies);
    cs = 1'b1;
    tick(4);
    for (int i = 0; i < dummies; i++) pulse(1'b0, 1'b0, 1'b0, "R2 dummy");
    pulse(1'b1, 1'b0, 1'b0, "R3 start");
    pulse(op[1], 1'b0, 1'b0, "R3 opcode");
    pulse(op[0], 1'b0, 1'b0, "R3 opcode");
    for (int i = AW - 1; i >= 0; i--) pulse(a[i], 1'b0, 1'b0, "R3 address");
  endtask

  // Streams nwords words; stops after cut data bits when cut >= 0.
  task automatic read_words(logic [AW-1:0] a, int nwords, int cut, string tag);
    int sent = 0;
    pulse(1'b0, 1'b1, 1'b0, "R5 lead zero");
    for (int w = 0; w < nwords; w++) begin
      logic [DW-1:0] word;
      word = model[(int'(a) + w) % DEPTH];
      for (int b = DW - 1; b >= 0; b--) begin
        if (cut >= 0 && sent == cut) return;
        pulse(1'b0, 1'b1, word[b], (w == 0) ? tag : "R7 R8 stream");
        sent++;
      end
    end
  endtask

  task automatic end_cmd(string tag);
    cs = 1'b0;
    di = 1'b0;
    tick(6);
    direct_check(do_oe === 1'b0, tag, {15'd0, do_oe}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    tick(5);
    // R11: reset state
    direct_check(do_oe === 1'b0, "R11 reset oe", {15'd0, do_oe}, 16'd0);
    rst_n = 1'b1;
    tick(2);

    // R10: preload every word
    for (int a = 0; a < DEPTH; a++) begin
      pre_we = 1'b1; pre_addr = AW'(a); pre_data = pat(a); model[a] = pat(a);
      tick(1);
    end
    pre_we = 1'b0;
    tick(2);

    // R1: activity with select low starts nothing
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0, 1'b0, "R1 standby");

    // R3 R5 R6: single read, no dummies
    send_cmd(2'b10, 6'h05, 0);
    read_words(6'h05, 1, -1, "R6 word");
    end_cmd("R1 after read");

    // R2: seven dummy clocks before the start bit
    send_cmd(2'b10, 6'h2A, 7);
    read_words(6'h2A, 1, -1, "R2 R6 word");
    end_cmd("R1 after dummy read");

    // R7 R8: three words from the top address, wrapping to zero
    send_cmd(2'b10, 6'h3F, 0);
    read_words(6'h3F, 3, -1, "R8 top word");
    end_cmd("R1 after wrap");

    // R4: unknown opcodes are disregarded until select drops
    send_cmd(2'b11, 6'h05, 0);
    for (int i = 0; i < 20; i++) pulse(1'(i % 2), 1'b0, 1'b0, "R4 ignored");
    end_cmd("R4 end");
    send_cmd(2'b01, 6'h12, 2);
    for (int i = 0; i < 20; i++) pulse(1'b1, 1'b0, 1'b0, "R4 ignored");
    end_cmd("R4 end");

    // R9: abort mid-word, then a fresh command with dummies
    send_cmd(2'b10, 6'h0A, 0);
    read_words(6'h0A, 1, 6, "R9 partial");
    end_cmd("R9 abort oe");
    send_cmd(2'b10, 6'h11, 3);
    read_words(6'h11, 1, -1, "R9 after abort");
    end_cmd("R9 end");

    // R10: overwrite one word and read it back
    pre_we = 1'b1; pre_addr = 6'h05; pre_data = 16'hBEEF; model[5] = 16'hBEEF;
    tick(1);
    pre_we = 1'b0;
    tick(2);
    send_cmd(2'b10, 6'h05, 1);
    read_words(6'h05, 1, -1, "R10 preload");
    end_cmd("R10 end");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule